// File: doc/BRIEF.md
# Ramped FSK Frequency Sweeper

This block drives a 48-bit frequency tuning word that glides between a low endpoint and a high endpoint, steered by the level of an FSK data input. It does not jump between the two tones. A programmable countdown sets how long each intermediate frequency is held, and each expiry of that countdown moves the tuning word by a programmable step toward the endpoint that the current FSK level selects. When the word reaches that endpoint it stays there until the FSK input changes level again. The time spent at an endpoint is therefore set by the data and can far exceed the time spent at any intermediate step.

Configuration arrives through a synchronous write port into shadow registers. An update strobe copies all shadow values into the working set in one cycle, so a half-written value is never used. The step size and the dwell count may be changed during a sweep to build piecewise, nonlinear glides. A clear control bit holds the tuning word at zero so that a sweep can start from a known origin.

Top module: `fsk_ramp_sweeper`

## Requirements
- R1: While reset is asserted and after its release, `ftw_o` is zero and every shadow and working setting is zero.
- R2: `fsk_in` passes through a two-stage synchronizer. A level change in either direction restarts the dwell counter. With dwell value N, the first step appears on `ftw_o` N+3 clock cycles after the first rising edge that samples the new level.
- R3: During a sweep, successive steps on `ftw_o` are exactly N+1 clock cycles apart.
- R4: With the synchronized FSK level high, each step adds the step word. Once the sum reaches or passes the high endpoint, `ftw_o` equals the high endpoint and stepping stops.
- R5: With the synchronized FSK level low, each step subtracts the step word. Once the result would reach or fall below the low endpoint, `ftw_o` equals the low endpoint and stepping stops.
- R6: Between steps `ftw_o` does not change. After an endpoint is reached it holds until the next FSK level change. A level change during a sweep reverses direction from the current value.
- R7: While the working clear bit is 1, `ftw_o` is zero and FSK level changes start nothing. Once the bit returns to 0, the next sweep starts from zero.
- R8: A write with `wr_en` stores `wr_data` in a shadow register selected by `wr_addr`: 0 = low endpoint, 1 = high endpoint, 2 = step word, 3 = dwell N (bits 19:0), 4 = control (bit 0 = clear). Shadow values have no effect until `upd_stb`. An update copies the shadow values held before any write in the same cycle.
- R9: A step word or dwell value updated during a sweep is used from the next step (step word) or the next counter reload (dwell) onward.
- R10: Arithmetic does not wrap. An upward step whose sum exceeds 2^48−1 still lands on the high endpoint, and a downward step never goes below the low endpoint.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Shadow register write enable |
| wr_addr | input | 3 | Shadow register select |
| wr_data | input | 48 | Write data |
| upd_stb | input | 1 | Copy all shadow values into the working set |
| fsk_in | input | 1 | FSK data level (asynchronous) |
| ftw_o | output | 48 | Frequency tuning word |

## Verification
The assertions assume that the low endpoint does not exceed the high endpoint and that the working settings change only through the update strobe. The bounds checks compare the new word against the endpoint that was in force at the step. The stimulus always programs the endpoints in order. It changes step and dwell only through updates, sometimes in the middle of a sweep, and it keeps N at 1 or above, except during a deliberate zero-step window with no update applied. FSK toggles are held for at least one cycle, and one short glitch tests reversal through the synchronizer.

// File: rtl/fsk_ramp_pkg.sv
package fsk_ramp_pkg;
    localparam int REG_ADDR_W = 3;

    typedef enum logic [REG_ADDR_W-1:0] {
        RA_LOW  = 3'd0,
        RA_HIGH = 3'd1,
        RA_STEP = 3'd2,
        RA_RATE = 3'd3,
        RA_CTRL = 3'd4
    } reg_addr_e;
endpackage

// File: rtl/fsk_ramp_regs.sv
module fsk_ramp_regs
    import fsk_ramp_pkg::*;
#(
    parameter int FTW_W  = 48,
    parameter int RATE_W = 20
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [REG_ADDR_W-1:0] wr_addr,
    input  logic [FTW_W-1:0]      wr_data,
    input  logic                  upd_stb,
    output logic [FTW_W-1:0]      lo_o,
    output logic [FTW_W-1:0]      hi_o,
    output logic [FTW_W-1:0]      step_o,
    output logic [RATE_W-1:0]     rate_o,
    output logic                  clr_o
);
    typedef struct packed {
        logic [FTW_W-1:0]  lo;
        logic [FTW_W-1:0]  hi;
        logic [FTW_W-1:0]  step;
        logic [RATE_W-1:0] rate;
        logic              clr;
    } cfg_t;

    typedef struct packed {
        cfg_t sh;
        cfg_t act;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (upd_stb) st_d.act = st_q.sh;
        if (wr_en) begin
            case (reg_addr_e'(wr_addr))
                RA_LOW:  st_d.sh.lo   = wr_data;
                RA_HIGH: st_d.sh.hi   = wr_data;
                RA_STEP: st_d.sh.step = wr_data;
                RA_RATE: st_d.sh.rate = wr_data[RATE_W-1:0];
                RA_CTRL: st_d.sh.clr  = wr_data[0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign lo_o   = st_q.act.lo;
    assign hi_o   = st_q.act.hi;
    assign step_o = st_q.act.step;
    assign rate_o = st_q.act.rate;
    assign clr_o  = st_q.act.clr;
endmodule

// File: rtl/fsk_ramp_sync.sv
module fsk_ramp_sync #(
    parameter int SYNC_N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fsk_in,
    output logic lvl_o,
    output logic chg_o
);
    localparam int CHAIN_W = SYNC_N + 1;

    logic [CHAIN_W-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[CHAIN_W-2:0], fsk_in};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign lvl_o = chain_q[SYNC_N-1];
    assign chg_o = chain_q[SYNC_N-1] ^ chain_q[SYNC_N];
endmodule

// File: rtl/fsk_ramp_timer.sv
module fsk_ramp_timer #(
    parameter int RATE_W = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              chg_i,
    input  logic [RATE_W-1:0] rate_i,
    input  logic              halt_i,
    output logic              tick_o,
    output logic              run_o
);
    typedef struct packed {
        logic              run;
        logic [RATE_W-1:0] cnt;
    } tmr_t;

    tmr_t t_d, t_q;

    assign tick_o = t_q.run && (t_q.cnt == '0) && !chg_i && !clr_i;
    assign run_o  = t_q.run;

    always_comb begin
        t_d = t_q;
        if (clr_i) begin
            t_d = '0;
        end else if (chg_i) begin
            t_d.run = 1'b1;
            t_d.cnt = rate_i;
        end else if (t_q.run) begin
            if (t_q.cnt == '0) begin
                if (halt_i) t_d.run = 1'b0;
                else        t_d.cnt = rate_i;
            end else begin
                t_d.cnt = t_q.cnt - 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end
endmodule

// File: rtl/fsk_ramp_accum.sv
module fsk_ramp_accum #(
    parameter int FTW_W = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             tick_i,
    input  logic             up_i,
    input  logic [FTW_W-1:0] lo_i,
    input  logic [FTW_W-1:0] hi_i,
    input  logic [FTW_W-1:0] step_i,
    output logic             halt_o,
    output logic [FTW_W-1:0] ftw_o
);
    localparam int EXT_W = FTW_W + 1;

    logic [FTW_W-1:0] acc_d, acc_q;
    logic [EXT_W-1:0] sum_up, floor_dn;
    logic             reach;

    always_comb begin
        sum_up   = {1'b0, acc_q} + {1'b0, step_i};
        floor_dn = {1'b0, lo_i} + {1'b0, step_i};
        reach    = up_i ? (sum_up >= {1'b0, hi_i}) : ({1'b0, acc_q} < floor_dn);
        halt_o   = tick_i && reach;
        acc_d    = acc_q;
        if (clr_i) begin
            acc_d = '0;
        end else if (tick_i) begin
            if (up_i) acc_d = reach ? hi_i : sum_up[FTW_W-1:0];
            else      acc_d = reach ? lo_i : (acc_q - step_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc_q <= '0;
        else        acc_q <= acc_d;
    end

    assign ftw_o = acc_q;
endmodule

// File: rtl/fsk_ramp_sweeper.sv
module fsk_ramp_sweeper
    import fsk_ramp_pkg::*;
#(
    parameter int FTW_W  = 48,
    parameter int RATE_W = 20,
    parameter int SYNC_N = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [REG_ADDR_W-1:0] wr_addr,
    input  logic [FTW_W-1:0]      wr_data,
    input  logic                  upd_stb,
    input  logic                  fsk_in,
    output logic [FTW_W-1:0]      ftw_o
);
    logic [FTW_W-1:0]  act_lo, act_hi, act_step;
    logic [RATE_W-1:0] act_rate;
    logic              act_clr;
    logic              fsk_lvl, fsk_chg;
    logic              step_tick, sweep_halt, tmr_run;

    fsk_ramp_regs #(.FTW_W(FTW_W), .RATE_W(RATE_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .upd_stb(upd_stb), .lo_o(act_lo), .hi_o(act_hi),
        .step_o(act_step), .rate_o(act_rate), .clr_o(act_clr)
    );

    fsk_ramp_sync #(.SYNC_N(SYNC_N)) u_sync (
        .clk(clk), .rst_n(rst_n), .fsk_in(fsk_in),
        .lvl_o(fsk_lvl), .chg_o(fsk_chg)
    );

    fsk_ramp_timer #(.RATE_W(RATE_W)) u_timer (
        .clk(clk), .rst_n(rst_n), .clr_i(act_clr), .chg_i(fsk_chg),
        .rate_i(act_rate), .halt_i(sweep_halt), .tick_o(step_tick), .run_o(tmr_run)
    );

    fsk_ramp_accum #(.FTW_W(FTW_W)) u_accum (
        .clk(clk), .rst_n(rst_n), .clr_i(act_clr), .tick_i(step_tick),
        .up_i(fsk_lvl), .lo_i(act_lo), .hi_i(act_hi), .step_i(act_step),
        .halt_o(sweep_halt), .ftw_o(ftw_o)
    );
endmodule

// File: rtl/fsk_ramp_sweeper_chk.sv
module fsk_ramp_sweeper_chk #(
    parameter int FTW_W  = 48,
    parameter int RATE_W = 20
) (
    input logic              clk,
    input logic              rst_n,
    input logic [FTW_W-1:0]  ftw,
    input logic [FTW_W-1:0]  lo,
    input logic [FTW_W-1:0]  hi,
    input logic [RATE_W-1:0] rate,
    input logic              clr,
    input logic              up,
    input logic              chg,
    input logic              tick,
    input logic              halt,
    input logic              run
);
    p_clear_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (ftw == '0));

    p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !clr) |=> $stable(ftw));

    p_upper_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && up) |=> (ftw <= $past(hi)));

    p_lower_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !up) |=> (ftw >= $past(lo)));

    p_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && (rate != '0)) |=> !tick);

    p_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (chg && !clr) |=> run);

    p_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        halt |=> !run);
endmodule

bind fsk_ramp_sweeper fsk_ramp_sweeper_chk #(.FTW_W(FTW_W), .RATE_W(RATE_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .ftw(ftw_o), .lo(act_lo), .hi(act_hi),
    .rate(act_rate), .clr(act_clr), .up(fsk_lvl), .chg(fsk_chg),
    .tick(step_tick), .halt(sweep_halt), .run(tmr_run)
);

// File: tb/fsk_ramp_sweeper_tb.sv
module fsk_ramp_sweeper_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [47:0] wr_data = '0;
    logic        upd_stb = 1'b0;
    logic        fsk_in = 1'b0;
    logic [47:0] ftw_o;

    int    n_vec = 0;
    int    n_bad = 0;
    int    wd = 0;
    bit    done = 1'b0;
    string cur = "R1";

    // behavioural reference state
    logic [63:0] sh_lo, sh_hi, sh_step, a_lo, a_hi, a_step;
    int          sh_rate, a_rate, m_cnt;
    bit          sh_clr, a_clr, m_run;
    bit [2:0]    m_s;
    logic [63:0] m_acc;

    fsk_ramp_sweeper u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .upd_stb(upd_stb), .fsk_in(fsk_in), .ftw_o(ftw_o)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        if (!rst_n) begin
            sh_lo = 0; sh_hi = 0; sh_step = 0; sh_rate = 0; sh_clr = 0;
            a_lo = 0; a_hi = 0; a_step = 0; a_rate = 0; a_clr = 0;
            m_cnt = 0; m_run = 0; m_s = 0; m_acc = 0;
        end else begin
            bit e, up, pl, halt;
            logic [63:0] nxt;
            e  = m_s[1] ^ m_s[2];
            up = m_s[1];
            pl = m_run && m_cnt == 0 && !e && !a_clr;
            halt = 0;
            nxt = m_acc;
            if (a_clr) nxt = 0;
            else if (pl) begin
                if (up) begin
                    if (m_acc + a_step >= a_hi) begin nxt = a_hi; halt = 1; end
                    else nxt = m_acc + a_step;
                end else begin
                    if (m_acc < a_lo + a_step) begin nxt = a_lo; halt = 1; end
                    else nxt = m_acc - a_step;
                end
            end
            if (a_clr) begin m_run = 0; m_cnt = 0; end
            else if (e) begin m_run = 1; m_cnt = a_rate; end
            else if (m_run) begin
                if (m_cnt == 0) begin
                    if (halt) m_run = 0; else m_cnt = a_rate;
                end else m_cnt = m_cnt - 1;
            end
            m_acc = nxt;
            if (upd_stb) begin
                a_lo = sh_lo; a_hi = sh_hi; a_step = sh_step;
                a_rate = sh_rate; a_clr = sh_clr;
            end
            if (wr_en) begin
                case (wr_addr)
                    3'd0: sh_lo = {16'd0, wr_data};
                    3'd1: sh_hi = {16'd0, wr_data};
                    3'd2: sh_step = {16'd0, wr_data};
                    3'd3: sh_rate = int'(wr_data[19:0]);
                    3'd4: sh_clr = wr_data[0];
                    default: ;
                endcase
            end
            m_s = {m_s[1:0], fsk_in};
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            n_vec++;
            if (ftw_o !== m_acc[47:0]) begin
                n_bad++;
                $display("FAIL %s: ftw_o actual %0d expected %0d at %0t",
                         cur, ftw_o, m_acc[47:0], $time);
            end
        end
    end

    always @(posedge clk) begin
        wd++;
        if (wd > 150000 && !done) begin
            done = 1'b1;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    task automatic wr(input logic [2:0] a, input logic [47:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic upd();
        @(negedge clk); upd_stb = 1'b1;
        @(negedge clk); upd_stb = 1'b0;
    endtask

    task automatic fsk(input logic v, input int hold);
        @(negedge clk); fsk_in = v;
        repeat (hold) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        cur = "R1";
        @(negedge clk);
        n_vec++;
        if (ftw_o !== 48'd0) begin
            n_bad++;
            $display("FAIL R1: reset ftw_o actual %0d expected 0", ftw_o);
        end
        repeat (3) @(negedge clk);

        cur = "R8";  // shadow writes alone change nothing
        wr(3'd0, 48'd1000);
        wr(3'd1, 48'd1250);
        wr(3'd2, 48'd100);
        wr(3'd3, 48'd3);
        fsk(1'b1, 10);
        fsk(1'b0, 10);
        upd();

        cur = "R4";
        fsk(1'b1, 70);
        cur = "R5";
        fsk(1'b0, 40);
        cur = "R6";  // reversal mid-sweep, then long dwell
        fsk(1'b1, 14);
        fsk(1'b0, 60);

        cur = "R9";  // rewrite step and dwell during a sweep
        fsk(1'b1, 6);
        wr(3'd2, 48'd30);
        wr(3'd3, 48'd1);
        upd();
        repeat (40) @(negedge clk);

        cur = "R2";  // one-cycle glitch through the synchronizer
        fsk(1'b0, 1);
        fsk(1'b1, 30);
        fsk(1'b0, 40);

        cur = "R3";
        wr(3'd3, 48'd5);
        wr(3'd2, 48'd50);
        upd();
        fsk(1'b1, 60);

        cur = "R7";
        wr(3'd4, 48'd1);
        upd();
        fsk(1'b0, 5);
        fsk(1'b1, 5);
        wr(3'd4, 48'd0);
        upd();
        repeat (5) @(negedge clk);
        fsk(1'b0, 5);
        fsk(1'b1, 60);

        cur = "R10";
        wr(3'd0, 48'd10);
        wr(3'd1, 48'hFFFF_FFFF_FFFF);
        wr(3'd2, 48'h8000_0000_0005);
        wr(3'd3, 48'd2);
        upd();
        fsk(1'b0, 20);
        fsk(1'b1, 30);
        fsk(1'b0, 30);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule